// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This block is the shifter of a 32-bit integer datapath. It takes the value to be shifted from the second source register (the rt operand) and moves it left, right with zero fill, right with sign fill, or rotates it in either direction. The result appears on the output in the same cycle. Nothing inside the block is registered.

The shift distance has two possible sources. One is the 5-bit amount field carried in the instruction. The other is the low bits of a register value, used by the variable-shift forms. A single select input chooses the source. The unit contains one logarithmic right-going network of five stages, and that network serves every mode. Left shifts and left rotates reverse the bit order before the network and again after it. Rotation feeds the bits that drop off one end back in at the other end. Instruction decode and register file access stay outside the block.

Top module: `shift_unit`

## Requirements
- R1: When the effective shift amount is 0, `result` equals `operand` for every `kind` code.
- R2: `kind` = 0 is a logical left shift. `result` = `operand` << n, and the vacated low bits are 0.
- R3: `kind` = 1 is a logical right shift. `result` = `operand` >> n, and the vacated high bits are 0. As an example, 0xFFFFFFF8 shifted right by 2 gives 0x3FFFFFFE.
- R4: `kind` = 2 is an arithmetic right shift. The vacated high bits copy `operand[31]`. As an example, 0xFFFFFFF8 (-8) shifted right by 2 gives 0xFFFFFFFE (-2).
- R5: `kind` = 3 rotates right by n. A bit leaving position 0 re-enters at position 31.
- R6: `kind` = 4 rotates left by n. A bit leaving position 31 re-enters at position 0.
- R7: With `use_reg` = 0, the amount n is `imm_amt`, and `reg_amt` has no effect on `result`.
- R8: With `use_reg` = 1, n is `reg_amt[4:0]`. Bits `reg_amt[31:5]` and `imm_amt` have no effect on `result`.
- R9: The `kind` codes 5, 6 and 7 are unused, and for these `result` equals `operand`.
- R10: `result` depends only on the present inputs. It settles within the cycle in which the inputs change, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 32 | Value to shift (rt register) |
| imm_amt | input | 5 | Shift amount from the instruction field |
| reg_amt | input | 32 | Register value whose low 5 bits give a variable amount |
| use_reg | input | 1 | 1 selects the register amount, 0 selects the field amount |
| kind | input | 3 | Operation: 0 left, 1 right logical, 2 right arithmetic, 3 rotate right, 4 rotate left |
| result | output | 32 | Shifted or rotated value |

## Verification
The bench sweeps every operation code, both amount sources and all 32 amounts over several operands. The operands include all-ones, a lone MSB, and negative and positive patterns.

- **Amount 0:** an amount of 0 exposes a rotate that wraps by a full width. It also exposes a stage wired with the wrong enable bit.
- **Negative operands:** a sign-fill error leaves zeros in the top bits where -2 is expected. A logical shift that fills with the sign bit would turn 0x3FFFFFFE negative.
- **Amount source:** the inactive amount source is always driven with conflicting garbage. The upper bits of the register value are filled with noise. A design that read the wrong source, or used more than five register bits, would shift by the wrong distance.
- **Unused codes and rotate direction:** the unused codes must pass the operand through unchanged. Swapped rotate directions show up at every amount except 0 and 16.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_ROL = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic reverse;   // mirror bits around the right-going network
        logic rotate;    // wrap instead of fill
        logic fill_bit;  // value shifted in when not rotating
        logic pass;      // unused code: forward operand
    } shift_ctrl_t;

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic [AW-1:0] imm_amt,
    input  logic [W-1:0]  reg_val,
    input  logic          use_reg,
    output logic [AW-1:0] amt
);

    logic unused_hi;
    assign unused_hi = ^reg_val[W-1:AW];

    always_comb begin
        amt = use_reg ? reg_val[AW-1:0] : imm_amt;
    end

endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         en,
    input  logic         rotate,
    input  logic         fill_bit,
    output logic [W-1:0] dout
);

    always_comb begin
        if (!en) begin
            dout = din;
        end else if (rotate) begin
            dout = {din[DIST-1:0], din[W-1:DIST]};
        end else begin
            dout = {{DIST{fill_bit}}, din[W-1:DIST]};
        end
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter  int W  = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] imm_amt,
    input  logic [W-1:0]  reg_amt,
    input  logic          use_reg,
    input  logic [2:0]    kind,
    output logic [W-1:0]  result
);

    shift_ctrl_t   ctrl_d;
    logic [AW-1:0] amt_d;
    logic [W-1:0]  chain_d [AW+1];
    logic [W-1:0]  mirror_in_d;
    logic [W-1:0]  mirror_out_d;

    function automatic logic [W-1:0] bit_mirror(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = v[W-1-i];
        end
        return r;
    endfunction

    shift_amt_sel #(.W(W), .AW(AW)) u_amt (
        .imm_amt (imm_amt),
        .reg_val (reg_amt),
        .use_reg (use_reg),
        .amt     (amt_d)
    );

    always_comb begin
        ctrl_d = '0;
        case (shift_kind_e'(kind))
            SK_LSL:  ctrl_d.reverse = 1'b1;
            SK_LSR:  ctrl_d.fill_bit = 1'b0;
            SK_ASR:  ctrl_d.fill_bit = operand[W-1];
            SK_ROR:  ctrl_d.rotate = 1'b1;
            SK_ROL: begin
                ctrl_d.rotate  = 1'b1;
                ctrl_d.reverse = 1'b1;
            end
            default: ctrl_d.pass = 1'b1;
        endcase
    end

    always_comb begin
        mirror_in_d = ctrl_d.reverse ? bit_mirror(operand) : operand;
    end

    assign chain_d[0] = mirror_in_d;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        shift_stage #(.W(W), .DIST(1 << k)) u_stage (
            .din      (chain_d[k]),
            .en       (amt_d[k]),
            .rotate   (ctrl_d.rotate),
            .fill_bit (ctrl_d.fill_bit),
            .dout     (chain_d[k+1])
        );
    end

    always_comb begin
        mirror_out_d = ctrl_d.reverse ? bit_mirror(chain_d[AW]) : chain_d[AW];
        result       = ctrl_d.pass ? operand : mirror_out_d;
    end

    // Checks on the settled combinational result
    always_comb begin
        if (amt_d == '0) begin
            a_r1_zero_amount: assert (result == operand);
        end
        if (kind == 3'd1 && amt_d != '0) begin
            a_r3_zero_fill: assert (result[W-1] == 1'b0);
        end
        if (kind == 3'd2) begin
            a_r4_sign_fill: assert (result[W-1] == operand[W-1]);
        end
        if (kind == 3'd3 || kind == 3'd4) begin
            a_r5_rotate_keeps_bits: assert ($countones(result) == $countones(operand));
        end
        if (kind > 3'd4) begin
            a_r9_unused_pass: assert (result == operand);
        end
        if (kind == 3'd0 && amt_d != '0) begin
            a_r2_low_zero: assert (result[0] == 1'b0);
        end
    end

endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;

    logic        clk = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  imm_amt = '0;
    logic [31:0] reg_amt = '0;
    logic        use_reg = 1'b0;
    logic [2:0]  kind = '0;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    shift_unit u_shift_unit (
        .operand (operand),
        .imm_amt (imm_amt),
        .reg_amt (reg_amt),
        .use_reg (use_reg),
        .kind    (kind),
        .result  (result)
    );

    function automatic logic [31:0] model(input logic [2:0] k, input logic [31:0] v, input int n);
        logic [31:0] r;
        case (k)
            3'd0: r = v << n;
            3'd1: r = v >> n;
            3'd2: r = $unsigned($signed(v) >>> n);
            3'd3: r = (n == 0) ? v : ((v >> n) | (v << (32 - n)));
            3'd4: r = (n == 0) ? v : ((v << n) | (v >> (32 - n)));
            default: r = v;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s kind=%0d src=%0d op=%h imm=%0d reg=%h: got %h expected %h",
                     tag, kind, use_reg, operand, imm_amt, reg_amt, result, exp);
        end
    endtask

    task automatic apply(input logic [2:0] k, input logic [31:0] v, input int n,
                         input bit src, input logic [31:0] noise);
        @(negedge clk);
        kind    = k;
        operand = v;
        use_reg = src;
        if (src) begin
            reg_amt = {noise[31:5], 5'(n)};
            imm_amt = ~5'(n);
        end else begin
            imm_amt = 5'(n);
            reg_amt = noise ^ 32'(~n);
        end
        #2;
    endtask

    initial begin
        logic [31:0] pats [6];
        string tag;
        pats[0] = 32'hFFFF_FFF8;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'h0000_0077;
        pats[3] = 32'hFFFF_FFFF;
        pats[4] = 32'h1234_5678;
        pats[5] = 32'hA5C3_0F01;

        // Reset state: all-zero inputs give a zero result (R1, R10)
        #3;
        check("R1", 32'h0);

        // Stated examples for -8 >> 2 (R3, R4)
        apply(3'd1, 32'hFFFF_FFF8, 2, 1'b0, 32'hDEAD_BEEF);
        check("R3", 32'h3FFF_FFFE);
        apply(3'd2, 32'hFFFF_FFF8, 2, 1'b1, 32'hDEAD_BEEF);
        check("R4", 32'hFFFF_FFFE);

        // Same-cycle response to changing inputs (R10)
        apply(3'd0, 32'h0000_0001, 31, 1'b0, 32'h0);
        check("R10", 32'h8000_0000);

        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 8; k++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int n = 0; n < 32; n++) begin
                        apply(3'(k), pats[p], n, s[0], 32'h9E37_79B9 * (p + 3 * n + 7 * k + 1));
                        case (k)
                            0: tag = "R2";
                            1: tag = "R3";
                            2: tag = "R4";
                            3: tag = "R5";
                            4: tag = "R6";
                            default: tag = "R9";
                        endcase
                        if (n == 0) tag = {tag, "/R1"};
                        tag = {tag, (s != 0) ? "/R8" : "/R7"};
                        check(tag, model(3'(k), pats[p], n));
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule